// File: doc/BRIEF.md
# Shared-Line Serial Port Interrupt Hub

This block is the glue logic for a multi-port serial card whose UARTs all share a single host interrupt line. The host sees one byte-wide I/O window. The block splits that window into consecutive 8-byte slots, one for each UART, and drives the chip select of the UART whose slot is addressed. It also routes that UART's read data back to the host.

One location is taken over by the block: offset 7 of slot 0, which would otherwise be the scratch register of the first UART. A host write there loads a per-port interrupt enable mask. A host read there returns a per-port mask of raw UART interrupt requests. The enable mask does not change the read value. Unused upper bits of the read value return 1.

The shared interrupt output is registered. It is the OR over every port of (request AND enable). The host treats this line as edge-triggered, so it reads the pending mask repeatedly until the mask shows no port it services. The port count is a parameter, and only 4 or 8 is allowed.

Top module: `sio_irq_hub`

## Requirements
- R1: A host access (host_sel high and host_rd or host_wr high) to window offset 8·n+k, with k from 0 to 7, asserts uart_cs[n] in the same cycle. At most one chip select is ever high.
- R2: An access to window offset 7, which is offset 7 of slot 0, asserts no chip select. This includes uart_cs[0].
- R3: A host write to window offset 7 loads host_wdata[NUM_PORTS-1:0] into the enable mask from the next clock. Bit n = 1 enables port n, and bit n = 0 disables it.
- R4: A host read of window offset 7 returns bit n equal to uart_irq[n] in the same cycle, whatever the enable mask holds.
- R5: With NUM_PORTS = 4, bits 7:4 of the read at window offset 7 are always 1.
- R6: A host read of any other offset in slot n returns uart_rdata[8·n+7:8·n]. host_rdata is 0 whenever no read is in progress.
- R7: host_irq at clock t+1 equals the OR over n of (uart_irq[n] AND enable[n]) sampled at clock t. Once that set becomes empty, host_irq stays low for at least one clock.
- R8: While rst_n is low, the enable mask is 0 and host_irq is 0.
- R9: When host_sel is low, or neither strobe is high, no chip select is asserted and the enable mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host address falls inside the card's window |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W (5) | Byte offset inside the window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| uart_cs | output | NUM_PORTS (4) | Per-UART chip select |
| uart_rdata | input | 8·NUM_PORTS (32) | Read data from each UART, port n in bits 8n+7:8n |
| uart_irq | input | NUM_PORTS (4) | Interrupt request from each UART |
| host_irq | output | 1 | Shared host interrupt |

## Verification
The assertions check four properties on every cycle:
- no more than one chip select is high;
- the intercepted offset never selects a UART;
- the enable mask follows an intercepted write on the next clock and otherwise holds;
- host_irq never rises unless some UART requested an interrupt in the cycle before.

Some behaviour depends on particular values and sequences, so only the bench scenarios can show it:
- reads of the pending mask with the enable mask clearing some requests;
- the forced-one upper bits;
- data returned from each slot;
- the low gap on host_irq when the enabled requests drain and a new request then arrives.

// File: rtl/sio_hub_pkg.sv
package sio_hub_pkg;
   localparam int SLOT_AW    = 3;
   localparam int SLOT_BYTES = 1 << SLOT_AW;
   localparam int DATA_W     = 8;
   localparam logic [SLOT_AW-1:0] CTL_OFS = SLOT_AW'(SLOT_BYTES - 1);
endpackage

// File: rtl/sio_hub_decode.sv
module sio_hub_decode
   import sio_hub_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   localparam int SLOT_W = $clog2(NUM_PORTS),
   localparam int ADDR_W = SLOT_W + SLOT_AW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_sel,
   input  logic                 host_rd,
   input  logic                 host_wr,
   input  logic [ADDR_W-1:0]    host_addr,
   output logic [NUM_PORTS-1:0] uart_cs,
   output logic                 ctl_hit,
   output logic [SLOT_W-1:0]    slot_idx
);
   logic access;
   logic [SLOT_AW-1:0] ofs;

   assign access   = host_sel & (host_rd | host_wr);
   assign slot_idx = host_addr[ADDR_W-1:SLOT_AW];
   assign ofs      = host_addr[SLOT_AW-1:0];
   assign ctl_hit  = access && (slot_idx == '0) && (ofs == CTL_OFS);

   for (genvar n = 0; n < NUM_PORTS; n++) begin : g_cs
      assign uart_cs[n] = access && !ctl_hit && (slot_idx == SLOT_W'(n));
   end

   // R1
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(uart_cs));
   // R2
   ctl_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |-> (uart_cs == '0));
   // R9
   idle_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_sel || !(host_rd || host_wr)) |-> (uart_cs == '0));
endmodule

// File: rtl/sio_hub_mask.sv
module sio_hub_mask #(
   parameter int NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic [NUM_PORTS-1:0] ld_val,
   output logic [NUM_PORTS-1:0] en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '0;
      else if (ld) en_q <= ld_val;
   end

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (en_q == $past(ld_val)));
   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(en_q));
endmodule

// File: rtl/sio_hub_rdmux.sv
module sio_hub_rdmux
   import sio_hub_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   localparam int SLOT_W = $clog2(NUM_PORTS)
) (
   input  logic                          rd_en,
   input  logic                          ctl_hit,
   input  logic [SLOT_W-1:0]             slot_idx,
   input  logic [NUM_PORTS-1:0]          raw_irq,
   input  logic [NUM_PORTS*DATA_W-1:0]   uart_rdata,
   output logic [DATA_W-1:0]             rdata
);
   logic [DATA_W-1:0] pend_byte;

   if (NUM_PORTS < DATA_W) begin : g_pad
      assign pend_byte = {{(DATA_W-NUM_PORTS){1'b1}}, raw_irq};
   end else begin : g_full
      assign pend_byte = raw_irq;
   end

   always_comb begin
      if (!rd_en)       rdata = '0;
      else if (ctl_hit) rdata = pend_byte;
      else              rdata = uart_rdata[int'(slot_idx)*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/sio_hub_irq.sv
module sio_hub_irq #(
   parameter int NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] req,
   input  logic [NUM_PORTS-1:0] en,
   output logic                 host_irq
);
   logic any_req;
   assign any_req = |(req & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_irq <= 1'b0;
      else        host_irq <= any_req;
   end

   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> $past(|req));
   // R8
   irq_reset_chk: assert property (@(posedge clk)
      !rst_n |-> !host_irq);
endmodule

// File: rtl/sio_irq_hub.sv
module sio_irq_hub
   import sio_hub_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   localparam int SLOT_W = $clog2(NUM_PORTS),
   localparam int ADDR_W = SLOT_W + SLOT_AW
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_sel,
   input  logic                        host_rd,
   input  logic                        host_wr,
   input  logic [ADDR_W-1:0]           host_addr,
   input  logic [DATA_W-1:0]           host_wdata,
   output logic [DATA_W-1:0]           host_rdata,
   output logic [NUM_PORTS-1:0]        uart_cs,
   input  logic [NUM_PORTS*DATA_W-1:0] uart_rdata,
   input  logic [NUM_PORTS-1:0]        uart_irq,
   output logic                        host_irq
);
   initial begin
      port_count_chk: assert (NUM_PORTS == 4 || NUM_PORTS == 8)
         else $error("NUM_PORTS must be 4 or 8");
   end

   logic                 ctl_hit;
   logic [SLOT_W-1:0]    slot_idx;
   logic [NUM_PORTS-1:0] en_q;

   sio_hub_decode #(.NUM_PORTS(NUM_PORTS)) dec_i (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .uart_cs(uart_cs),
      .ctl_hit(ctl_hit), .slot_idx(slot_idx));

   sio_hub_mask #(.NUM_PORTS(NUM_PORTS)) mask_i (
      .clk(clk), .rst_n(rst_n), .ld(ctl_hit & host_wr),
      .ld_val(host_wdata[NUM_PORTS-1:0]), .en_q(en_q));

   sio_hub_rdmux #(.NUM_PORTS(NUM_PORTS)) rd_i (
      .rd_en(host_sel & host_rd), .ctl_hit(ctl_hit), .slot_idx(slot_idx),
      .raw_irq(uart_irq), .uart_rdata(uart_rdata), .rdata(host_rdata));

   sio_hub_irq #(.NUM_PORTS(NUM_PORTS)) irq_i (
      .clk(clk), .rst_n(rst_n), .req(uart_irq), .en(en_q),
      .host_irq(host_irq));
endmodule

// File: tb/sio_irq_hub_tb.sv
module sio_irq_hub_tb_top;
   localparam int NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [3:0]  uart_cs;
   logic [31:0] uart_rdata = 32'h44332211;
   logic [3:0]  uart_irq = '0;
   logic        host_irq;

   int compared = 0, mismatched = 0;
   bit done = 0;

   int en_m  = 0;
   bit irq_m = 0;

   always #5 clk = ~clk;

   sio_irq_hub #(.NUM_PORTS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .uart_cs(uart_cs), .uart_rdata(uart_rdata),
      .uart_irq(uart_irq), .host_irq(host_irq));

   // behavioural reference, advanced on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_m  <= 0;
         irq_m <= 0;
      end else begin
         irq_m <= ((int'(uart_irq) & en_m) != 0);
         if (host_sel && host_wr && host_addr == 5'd7)
            en_m <= int'(host_wdata) % 16;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      int exp_cs = 0;
      int exp_rd = 0;
      int slot = int'(host_addr) / 8;
      bit acc = host_sel && (host_rd || host_wr);
      if (acc && host_addr != 5'd7) exp_cs = 1 << slot;
      if (host_sel && host_rd) begin
         if (host_addr == 5'd7) exp_rd = 8'hF0 | int'(uart_irq);
         else exp_rd = (int'(uart_rdata) >> (8 * slot)) & 8'hFF;
      end
      check({tag, " cs"},    int'(uart_cs),    exp_cs);
      check({tag, " rdata"}, int'(host_rdata), exp_rd);
      check({tag, " irq"},   int'(host_irq),   int'(irq_m));
   endtask

   task automatic step(input string tag, input bit s, input bit r, input bit w,
                       input int a, input int wd, input int irq);
      @(negedge clk);
      host_sel = s; host_rd = r; host_wr = w;
      host_addr = 5'(a); host_wdata = 8'(wd); uart_irq = 4'(irq);
      #1 compare_all(tag);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R8: reset state, requests present but masked
      step("R8 reset", 0, 0, 0, 0, 0, 4'hF);
      step("R8 reset", 0, 0, 0, 0, 0, 4'hF);
      @(negedge clk); rst_n = 1'b1;
      step("R8 after reset en=0", 0, 0, 0, 0, 0, 4'hF);
      step("R8 after reset en=0", 0, 0, 0, 0, 0, 4'hF);
      // R4 R5: raw pending read with enable 0
      step("R4 R5 pend raw", 1, 1, 0, 7, 0, 4'hA);
      // R9: write with sel low ignored
      step("R9 sel low write", 0, 0, 1, 7, 8'h0F, 4'hF);
      step("R9 no effect", 0, 0, 0, 0, 0, 4'hF);
      step("R9 no effect irq", 0, 0, 0, 0, 0, 4'hF);
      // R3: enable port 2 only
      step("R3 write en", 1, 0, 1, 7, 8'hF4, 4'h0);
      step("R3 idle", 0, 0, 0, 0, 0, 4'h2);
      step("R3 R7 masked", 0, 0, 0, 0, 0, 4'h2);
      step("R7 enabled req", 0, 0, 0, 0, 0, 4'h4);
      step("R7 irq high", 0, 0, 0, 0, 0, 4'h4);
      step("R4 pend while en", 1, 1, 0, 7, 0, 4'h5);
      // R7: drain then new request -> low gap
      step("R7 drain", 0, 0, 0, 0, 0, 4'h0);
      step("R7 gap", 0, 0, 0, 0, 0, 4'h4);
      step("R7 rise", 0, 0, 0, 0, 0, 4'h4);
      // R1 R2 R6: walk every offset, read and write
      for (int a = 0; a < 32; a++) begin
         step("R1 R2 R6 read", 1, 1, 0, a, 0, a % 16);
      end
      for (int a = 0; a < 32; a++) begin
         if (a != 7) step("R1 R2 write", 1, 0, 1, a, 8'h00, 0);
      end
      step("R2 write ctl", 1, 0, 1, 7, 8'h0F, 4'h0);
      // R6: new data pattern, read off
      uart_rdata = 32'hC3A55A3C;
      for (int p = 0; p < 4; p++) begin
         step("R6 slot data", 1, 1, 0, p * 8 + 3, 0, 4'h0);
         step("R6 no read", 1, 0, 0, p * 8 + 3, 0, 4'h0);
      end
      // R7: all enabled, random requests
      for (int i = 0; i < 40; i++) begin
         step("R7 random", 0, 0, 0, 0, 0, (i * 7 + 3) % 16);
      end
      // R3: enable changes mid-request
      step("R3 en off", 1, 0, 1, 7, 8'h00, 4'h8);
      step("R3 off effect", 0, 0, 0, 0, 0, 4'h8);
      step("R3 off irq", 0, 0, 0, 0, 0, 4'h8);
      step("R3 en 8", 1, 0, 1, 7, 8'h08, 4'h8);
      step("R3 on effect", 0, 0, 0, 0, 0, 4'h8);
      step("R3 on irq", 0, 0, 0, 0, 0, 4'h8);
      // R8: reset mid-run clears mask
      @(negedge clk); rst_n = 1'b0;
      step("R8 reset again", 0, 0, 0, 0, 0, 4'h8);
      @(negedge clk); rst_n = 1'b1;
      step("R8 mask cleared", 0, 0, 0, 0, 0, 4'h8);
      step("R8 mask cleared irq", 0, 0, 0, 0, 0, 4'h8);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule